// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block adds automatic flow control to a single UART channel. It watches the receiver FIFO fill level against a pair of thresholds. It drives the request-to-send and data-terminal-ready outputs (both active low) so that the far end stops sending when the FIFO nears full, and starts again once the FIFO has drained. The upper and lower thresholds form a hysteresis band, so a level that wobbles near one threshold does not make the pins toggle.

On the transmit side it combines three reasons to stop starting new characters into one hold signal: a clear-to-send input that has gone inactive, a data-set-ready input that has gone inactive, and a pause caused by a received Xoff character. A received Xon releases the pause. In Xon-Any mode, any received character releases it. The block also detects a second, programmable Xoff value as a special character. That event, or a received Xoff, raises a status-level interrupt flag, and a separate flag records that the special character was the cause. When in-band control is active and the receive FIFO crosses the thresholds, the block asks the transmitter to send an Xoff or an Xon. The shifters, FIFOs and baud generator sit outside this block and reach it only through its ports.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With `rts_auto_en`=1, `enhanced`=1 and `mcr_rts`=1, `rts_n` goes high in the cycle after the clock edge that sees `rx_level` >= `thr_hi`.
- R2: Once the FIFO-full state is set, it stays set (and `rts_n` stays high) while `rx_level` >= `thr_lo`. It clears, and `rts_n` returns low, at the edge after `rx_level` < `thr_lo` is seen.
- R3: `mcr_rts`=0 drives `rts_n` high at once, whatever the level and enables. `mcr_dtr`=0 does the same for `dtr_n`.
- R4: `dtr_mode[0]`=1 makes `dtr_n` follow the same hysteresis state as R1/R2, whatever the value of `enhanced`.
- R5: With `enhanced`=0, `rts_auto_en` has no effect, and `rts_n` equals the inverse of `mcr_rts`.
- R6: `tx_hold` is high, combinationally, when any of these holds: `cts_n`=1 with `cts_auto_en`=1 and `enhanced`=1; `dsr_n`=1 with `dtr_mode[1]`=1; or the in-band pause is set.
- R7: In-band control is active when `inband_en`=1 and `enhanced`=1. While it is active, a received character equal to `xoff_char` sets the pause at the edge that samples `rx_valid`. While paused, a received `xon_char` clears the pause.
- R8: With `xon_any_en`=1 and in-band control active, any received character other than `xoff_char` clears the pause.
- R9: `int5` is set by a received `xoff_char` while in-band control is active. It is also set by a received `xoff2_char` while `spec_en`=1 and `enhanced`=1. An `isr_read` pulse clears it, but a set in the same cycle wins.
- R10: `spec_flag` is set by the special-character match of R9. An `asr_read` pulse clears it, and a set in the same cycle wins.
- R11: While in-band control is active, `xoff_req` pulses high for one cycle after the FIFO-full state rises, and `xon_req` pulses high for one cycle after it falls. The two never go high together.
- R12: When in-band control goes inactive, the pause clears at the next edge. After reset, the full state, the pause, `int5` and `spec_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 8 | Receiver FIFO fill level (0..128) |
| thr_hi | input | 8 | Upper threshold |
| thr_lo | input | 8 | Lower threshold |
| enhanced | input | 1 | Enhanced mode enable |
| rts_auto_en | input | 1 | Automatic request-to-send control |
| cts_auto_en | input | 1 | Automatic clear-to-send gating |
| dtr_mode | input | 2 | Bit 0: automatic DTR output; bit 1: DSR gating |
| mcr_rts | input | 1 | Software request-to-send bit (1 = active) |
| mcr_dtr | input | 1 | Software data-terminal-ready bit (1 = active) |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| inband_en | input | 1 | In-band Xon/Xoff control enable |
| xon_any_en | input | 1 | Any character acts as Xon |
| spec_en | input | 1 | Special-character detection enable |
| xon_char | input | 8 | Xon character value |
| xoff_char | input | 8 | Xoff character value |
| xoff2_char | input | 8 | Special (second Xoff) character value |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| isr_read | input | 1 | Interrupt status read pulse |
| asr_read | input | 1 | Special-status read pulse |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| tx_hold | output | 1 | Do not start a new transmit character |
| xoff_req | output | 1 | Request to send Xoff (one-cycle pulse) |
| xon_req | output | 1 | Request to send Xon (one-cycle pulse) |
| int5 | output | 1 | Xoff/special-character interrupt flag |
| spec_flag | output | 1 | Special character caused the interrupt |

## Verification
The bench steps the level exactly onto each threshold and one below it. A design that compared with the wrong inclusiveness would move `rts_n` one level early or late, and one that dropped the hysteresis would release the pin while the level was still inside the band. It makes a status read and a new Xoff or special character land in the same cycle, which catches a clear that wrongly wins over the set. It sends `xoff_char` with Xon-Any enabled, where a wrong priority would resume instead of pause. It also switches `enhanced` off while automatic RTS is enabled, and drops the software RTS bit in the middle of the band; a wrong design would leave the pin under automatic control in either case.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
  parameter int unsigned LVL_W  = 8;
  parameter int unsigned CHAR_W = 8;
  typedef logic [LVL_W-1:0]  level_t;
  typedef logic [CHAR_W-1:0] char_t;

  // hysteresis step: set at or above hi, hold until strictly below lo
  function automatic logic hyst_next(logic cur, level_t lvl, level_t hi, level_t lo);
    if (cur) return !(lvl < lo);
    return lvl >= hi;
  endfunction

  // character resumes a paused transmitter
  function automatic logic resumes(logic any, char_t c, char_t xon, char_t xoff);
    return (c != xoff) && (any || (c == xon));
  endfunction
endpackage

// File: rtl/uaf_hyst.sv
module uaf_hyst
  import uaf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  level_t level,
  input  level_t thr_hi,
  input  level_t thr_lo,
  output logic   full,
  output logic   rose,
  output logic   fell
);
  logic full_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      full_d <= 1'b0;
    end else begin
      full   <= hyst_next(full, level, thr_hi, thr_lo);
      full_d <= full;
    end
  end

  assign rose = full & ~full_d;
  assign fell = ~full & full_d;

  assert_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && level >= thr_hi) |=> full);
  assert_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && level >= thr_lo) |=> full);
  assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && level < thr_lo) |=> !full);
endmodule

// File: rtl/uaf_inband.sv
module uaf_inband
  import uaf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  logic  xon_any,
  input  logic  spec_on,
  input  logic  rx_valid,
  input  char_t rx_data,
  input  char_t xon_c,
  input  char_t xoff_c,
  input  char_t xoff2_c,
  input  logic  isr_read,
  input  logic  asr_read,
  output logic  paused,
  output logic  int5,
  output logic  spec_flag
);
  logic xoff_hit, xon_hit, spec_hit, int_set;

  assign xoff_hit = rx_valid & active & (rx_data == xoff_c);
  assign xon_hit  = rx_valid & active & paused & resumes(xon_any, rx_data, xon_c, xoff_c);
  assign spec_hit = rx_valid & spec_on & (rx_data == xoff2_c);
  assign int_set  = xoff_hit | spec_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused    <= 1'b0;
      int5      <= 1'b0;
      spec_flag <= 1'b0;
    end else begin
      if (!active)       paused <= 1'b0;
      else if (xoff_hit) paused <= 1'b1;
      else if (xon_hit)  paused <= 1'b0;
      if (int_set)       int5 <= 1'b1;
      else if (isr_read) int5 <= 1'b0;
      if (spec_hit)      spec_flag <= 1'b1;
      else if (asr_read) spec_flag <= 1'b0;
    end
  end

  assert_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_hit |=> paused);
  assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xon_hit |=> !paused);
  assert_int_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int5 && isr_read && !int_set) |=> !int5);
  assert_spec_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spec_hit |=> (spec_flag && int5));
  assert_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !paused);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uaf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   thr_hi,
  input  logic [LVL_W-1:0]   thr_lo,
  input  logic               enhanced,
  input  logic               rts_auto_en,
  input  logic               cts_auto_en,
  input  logic [1:0]         dtr_mode,
  input  logic               mcr_rts,
  input  logic               mcr_dtr,
  input  logic               cts_n,
  input  logic               dsr_n,
  input  logic               inband_en,
  input  logic               xon_any_en,
  input  logic               spec_en,
  input  logic [CHAR_W-1:0]  xon_char,
  input  logic [CHAR_W-1:0]  xoff_char,
  input  logic [CHAR_W-1:0]  xoff2_char,
  input  logic               rx_valid,
  input  logic [CHAR_W-1:0]  rx_data,
  input  logic               isr_read,
  input  logic               asr_read,
  output logic               rts_n,
  output logic               dtr_n,
  output logic               tx_hold,
  output logic               xoff_req,
  output logic               xon_req,
  output logic               int5,
  output logic               spec_flag
);
  logic full, full_rose, full_fell, paused;
  logic inb_active, rts_auto, cts_gate, dsr_gate;

  assign inb_active = inband_en & enhanced;
  assign rts_auto   = rts_auto_en & enhanced;
  assign cts_gate   = cts_auto_en & enhanced & cts_n;
  assign dsr_gate   = dtr_mode[1] & dsr_n;

  uaf_hyst u_hyst (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .full(full), .rose(full_rose), .fell(full_fell)
  );

  uaf_inband u_inb (
    .clk(clk), .rst_n(rst_n), .active(inb_active), .xon_any(xon_any_en),
    .spec_on(spec_en & enhanced), .rx_valid(rx_valid), .rx_data(rx_data),
    .xon_c(xon_char), .xoff_c(xoff_char), .xoff2_c(xoff2_char),
    .isr_read(isr_read), .asr_read(asr_read),
    .paused(paused), .int5(int5), .spec_flag(spec_flag)
  );

  assign rts_n    = ~mcr_rts | (rts_auto & full);
  assign dtr_n    = ~mcr_dtr | (dtr_mode[0] & full);
  assign tx_hold  = paused | cts_gate | dsr_gate;
  assign xoff_req = inb_active & full_rose;
  assign xon_req  = inb_active & full_fell;

  assert_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcr_rts |-> rts_n) and (!mcr_dtr |-> dtr_n));
  assert_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enhanced |-> (rts_n == !mcr_rts));
  assert_cts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto_en && enhanced && cts_n) |-> tx_hold);
  assert_req_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xoff_req, xon_req}));
endmodule

// File: tb/sim_uart_flow_ctrl.sv
module sim_uart_flow_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_level = 0, thr_hi = 8'd96, thr_lo = 8'd32;
  logic enhanced = 0, rts_auto_en = 0, cts_auto_en = 0;
  logic [1:0] dtr_mode = 0;
  logic mcr_rts = 1, mcr_dtr = 1, cts_n = 0, dsr_n = 0;
  logic inband_en = 0, xon_any_en = 0, spec_en = 0;
  logic [7:0] xon_char = 8'h11, xoff_char = 8'h13, xoff2_char = 8'h5A;
  logic rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic isr_read = 0, asr_read = 0;
  logic rts_n, dtr_n, tx_hold, xoff_req, xon_req, int5, spec_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_flow_ctrl u0 (.*);

  // behavioural reference state
  bit m_full, m_prev, m_pause, m_int, m_spec;

  always @(posedge clk) begin
    bit inb, xo, sp, rs;
    if (!rst_n) begin
      m_full = 0; m_prev = 0; m_pause = 0; m_int = 0; m_spec = 0;
    end else begin
      inb = inband_en && enhanced;
      xo  = rx_valid && inb && rx_data == xoff_char;
      sp  = rx_valid && spec_en && enhanced && rx_data == xoff2_char;
      rs  = rx_valid && inb && m_pause && !xo && (xon_any_en || rx_data == xon_char);
      m_prev = m_full;
      if (int'(rx_level) >= int'(thr_hi)) m_full = 1;
      else if (int'(rx_level) < int'(thr_lo)) m_full = 0;
      if (!inb) m_pause = 0; else if (xo) m_pause = 1; else if (rs) m_pause = 0;
      if (xo || sp) m_int = 1; else if (isr_read) m_int = 0;
      if (sp) m_spec = 1; else if (asr_read) m_spec = 0;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit inb;
    inb = inband_en && enhanced;
    chk("R1 R2 R3 R5 rts_n", rts_n, !mcr_rts || (rts_auto_en && enhanced && m_full));
    chk("R3 R4 dtr_n", dtr_n, !mcr_dtr || (dtr_mode[0] && m_full));
    chk("R6 R7 R8 R12 tx_hold", tx_hold,
        m_pause || (cts_auto_en && enhanced && cts_n) || (dtr_mode[1] && dsr_n));
    chk("R11 xoff_req", xoff_req, inb && m_full && !m_prev);
    chk("R11 xon_req", xon_req, inb && !m_full && m_prev);
    chk("R9 int5", int5, m_int);
    chk("R10 spec_flag", spec_flag, m_spec);
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); compare(); end
  endtask

  task automatic rx(logic [7:0] c);
    rx_valid = 1; rx_data = c; tick(); rx_valid = 0; tick();
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R12 reset int5", int5, 1'b0);
    chk("R12 reset rts_n", rts_n, 1'b0);
    rst_n = 1; tick();
    // R1 / R2 threshold edges
    enhanced = 1; rts_auto_en = 1; dtr_mode = 2'b01;
    rx_level = 95; tick(2); chk("R1 below hi", rts_n, 1'b0);
    rx_level = 96; tick(); chk("R1 at hi", rts_n, 1'b1);
    rx_level = 32; tick(2); chk("R2 at lo held", rts_n, 1'b1);
    chk("R4 dtr follows", dtr_n, 1'b1);
    rx_level = 31; tick(); chk("R2 below lo released", rts_n, 1'b0);
    // R3 override in the band
    rx_level = 120; tick(2); rx_level = 60; mcr_rts = 0; #0;
    tick(); chk("R3 mcr_rts low", rts_n, 1'b1);
    mcr_rts = 1; rx_level = 0; tick(2);
    // R5 not enhanced; R4 dtr regardless
    enhanced = 0; rx_level = 110; tick(2);
    chk("R5 no auto rts", rts_n, 1'b0);
    chk("R4 dtr without enhanced", dtr_n, 1'b1);
    rx_level = 0; tick(2); enhanced = 1;
    // R6 gates
    cts_auto_en = 1; cts_n = 1; tick(); chk("R6 cts hold", tx_hold, 1'b1);
    cts_n = 0; dtr_mode = 2'b10; dsr_n = 1; tick(); chk("R6 dsr hold", tx_hold, 1'b1);
    dsr_n = 0; tick();
    // R7 / R8 / R11 in-band
    inband_en = 1; tick();
    rx(8'h41); chk("R7 plain char no pause", tx_hold, 1'b0);
    rx(8'h13); chk("R7 xoff pauses", tx_hold, 1'b1);
    rx(8'h41); chk("R7 other char keeps pause", tx_hold, 1'b1);
    rx(8'h11); chk("R7 xon resumes", tx_hold, 1'b0);
    xon_any_en = 1; rx(8'h13); rx(8'h13); chk("R8 xoff still pauses", tx_hold, 1'b1);
    rx(8'h42); chk("R8 any resumes", tx_hold, 1'b0);
    rx_level = 100; tick(); chk("R11 xoff req", xoff_req, 1'b1);
    rx_level = 10; tick(2);
    // R9 / R10 same-cycle set and clear
    isr_read = 1; tick(); isr_read = 0;
    spec_en = 1;
    rx_valid = 1; rx_data = 8'h5A; isr_read = 1; asr_read = 1; tick();
    rx_valid = 0; isr_read = 0; asr_read = 0; tick();
    chk("R9 set wins", int5, 1'b1); chk("R10 set wins", spec_flag, 1'b1);
    asr_read = 1; tick(); asr_read = 0; tick(); chk("R10 cleared", spec_flag, 1'b0);
    // R12 disable clears pause
    rx(8'h13); inband_en = 0; tick(2); chk("R12 pause cleared", tx_hold, 1'b0);
    // mixed pseudo-random run
    for (int i = 0; i < 3000; i++) begin
      lfsr = nxt(lfsr);
      rx_level = {1'b0, lfsr[6:0]} + {7'b0, lfsr[15]};
      rx_valid = lfsr[7];
      case (lfsr[9:8]) 2'd0: rx_data = 8'h11; 2'd1: rx_data = 8'h13;
                       2'd2: rx_data = 8'h5A; default: rx_data = lfsr[15:8]; endcase
      isr_read = lfsr[10] & lfsr[3]; asr_read = lfsr[11] & lfsr[4];
      cts_n = lfsr[12]; dsr_n = lfsr[13];
      if (i % 97 == 0) begin
        inband_en = lfsr[0]; xon_any_en = lfsr[1]; enhanced = lfsr[2] | lfsr[5];
        dtr_mode = lfsr[14:13]; mcr_rts = lfsr[3] | lfsr[6]; mcr_dtr = lfsr[4] | lfsr[6];
        thr_hi = 8'd40 + {4'b0, lfsr[11:8]} * 8'd5; thr_lo = thr_hi - 8'd20;
      end
      tick();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule